// File: doc/BRIEF.md
# Smart Card Supply Activation Sequencer

This block powers one smart card slot up and down under the control of a byte-wide control/status register. A host write places a two-bit supply level in the top of the register. If the slot is idle, the write switches the card supply on and starts an activation sequence. The sequence waits for an external supply-good flag, then enables the I/O line, starts the card clock and finally releases card reset after a fixed number of cycles.

Deactivation can be started by any of these:
- a card event;
- the supply-good flag dropping;
- a host write of level zero;
- an armed supply-fault input;
- the external supply timer expiring while the slot waits in the hold mode.

Deactivation tears the lines down in a fixed order: reset low, then clock stopped, then I/O low. Each step is a phase of `DEACT_CYC` cycles, and the supply is switched off only after the last one. A fault also clears the level field and the fault-arm bit at once. It latches a lockout that software must clear by writing level zero before any new activation is accepted.

Register layout:

| Bits | Field | Access |
|------|-------|--------|
| 7:6 | Supply level: 00 off, 01 1.8 V, 10 3.0 V, 11 5 V | read/write |
| 5 | Ready mode | read/write |
| 4 | Fault arm | read/write |
| 3 | Supply stable | read-only |
| 2 | Fault lockout | read-only |
| 1:0 | Always 0 | read-only |

Top module: `card_supply_seq`

## Requirements
- R1: After reset, `rd_data` reads 0x00, and `supply_en`, `vsel`, `card_rst`, `card_clk_en` and `card_io_en` are all 0.
- R2: Level field encoding is in bits 7:6: 00 off, 01 1.8 V, 10 3.0 V, 11 5 V.
  - A single write with a non-zero level while the slot is off and not locked sets `supply_en` to 1 and `vsel` to that code in the next cycle.
  - `vsel` is non-zero exactly while `supply_en` is 1.
- R3: With ready mode (bit 5) set, activation proceeds as follows:
  - `card_io_en` rises one cycle after `supply_good` is seen high.
  - `card_clk_en` rises `ACT_STEP` cycles after `card_io_en`.
  - `card_rst` rises `RST_DLY` cycles after `card_clk_en`.
  - `card_rst` is never 1 unless clock, I/O and supply are on.
- R4: With ready mode clear, `supply_good` does not advance activation. An assertion of `tmr_expired` while waiting starts deactivation, and the level field then reads 00.
- R5: While activation has passed the wait step, a `card_event` pulse or `supply_good` low starts deactivation.
- R6: Deactivation order, with reset dropped in the cycle after the trigger:
  - `card_clk_en` falls `DEACT_CYC` cycles after reset drops.
  - `card_io_en` falls `DEACT_CYC` cycles after the clock stops.
  - `supply_en` falls `DEACT_CYC` cycles after that, and never while reset, clock or I/O is still on.
- R7: With fault arm (bit 4) set, `supply_fault` starts deactivation. In the next cycle the level field and bit 4 read 0 and the lockout bit (bit 2) reads 1.
- R8: While locked out, a non-zero level write has no effect and `supply_en` stays 0. A write with level 00 clears the lockout, after which a non-zero write activates again.
- R9: A non-zero level write while the slot is not off is ignored: the level field, `vsel` and the card lines keep their values. A write of level 00 while the slot is on starts deactivation.
- R10: Status bit 3 reads 1 exactly when activation is complete (`card_rst` high) and `supply_good` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (level, ready mode, fault arm, stable, lockout) |
| supply_good | input | 1 | Card supply is within range |
| card_event | input | 1 | Card insertion/removal event pulse |
| supply_fault | input | 1 | Main supply fault indication |
| tmr_expired | input | 1 | External supply timer expiry pulse |
| vsel | output | 2 | Supply level code to the regulator, 0 when off |
| supply_en | output | 1 | Card supply enable |
| card_rst | output | 1 | Card reset line, 1 = released |
| card_clk_en | output | 1 | Card clock gate |
| card_io_en | output | 1 | Card I/O line enable |

## Verification
A register write or an input event takes effect at the next rising edge. From there each phase boundary falls a whole number of phases later: `ACT_STEP` and `RST_DLY` cycles during activation, and `DEACT_CYC` cycles per step during teardown. The bench drives every input just after a falling edge and samples just after the next falling edge. It steps exactly the computed number of cycles before each sample, and checks both the last cycle before each edge of a line and the first cycle after it. Randomized runs vary the level, the cause of deactivation and the time spent active. The expected register image for each case comes from a bench packing function.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [2:0] {
    S_OFF  = 3'd0,
    S_WAIT = 3'd1,
    S_IO   = 3'd2,
    S_CLK  = 3'd3,
    S_ON   = 3'd4,
    S_DRST = 3'd5,
    S_DCLK = 3'd6,
    S_DIO  = 3'd7
  } seq_state_t;

  localparam int LVL_HI     = 7;
  localparam int LVL_LO     = 6;
  localparam int RDY_BIT    = 5;
  localparam int ARM_BIT    = 4;
  localparam int STABLE_BIT = 3;
  localparam int LOCK_BIT   = 2;

  // True on the last cycle of a phase of 'len' cycles.
  function automatic logic phase_end(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic logic [7:0] pack_status(input logic [1:0] lvl, input logic rdy,
                                             input logic arm, input logic stable,
                                             input logic lock);
    logic [7:0] r;
    r = 8'h00;
    r[LVL_HI:LVL_LO] = lvl;
    r[RDY_BIT]       = rdy;
    r[ARM_BIT]       = arm;
    r[STABLE_BIT]    = stable;
    r[LOCK_BIT]      = lock;
    return r;
  endfunction

endpackage

// File: rtl/card_seq_regs.sv
module card_seq_regs
  import card_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       supply_fault,
  input  logic       slot_off,
  input  logic       deact_go,
  input  logic       stable,
  output logic [7:0] rd_data,
  output logic       start,
  output logic [1:0] start_lvl,
  output logic       stop_req,
  output logic       fault_hit,
  output logic       rdy_mode,
  output logic       locked
);

  logic [1:0] lvl_q;
  logic       rdy_q;
  logic       arm_q;
  logic       lock_q;
  logic [1:0] wr_lvl;

  assign wr_lvl    = wr_data[LVL_HI:LVL_LO];
  assign fault_hit = supply_fault && arm_q;
  assign start     = wr_en && (wr_lvl != 2'b00) && slot_off && !lock_q && !fault_hit;
  assign start_lvl = wr_lvl;
  assign stop_req  = wr_en && (wr_lvl == 2'b00);
  assign rdy_mode  = rdy_q;
  assign locked    = lock_q;
  assign rd_data   = pack_status(lvl_q, rdy_q, arm_q, stable, lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= 2'b00;
      rdy_q  <= 1'b0;
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      if (wr_en) begin
        rdy_q <= wr_data[RDY_BIT];
        arm_q <= wr_data[ARM_BIT];
      end
      if (deact_go) begin
        lvl_q <= 2'b00;
      end
      if (stop_req) begin
        lvl_q  <= 2'b00;
        lock_q <= 1'b0;
      end else if (start) begin
        lvl_q <= wr_lvl;
      end
      if (fault_hit) begin
        lvl_q  <= 2'b00;
        arm_q  <= 1'b0;
        lock_q <= 1'b1;
      end
    end
  end

  a_r7_fault_clears: assert property (@(posedge clk) disable iff (!rst_n)
    fault_hit |=> (lvl_q == 2'b00) && lock_q && !arm_q);

  a_r9_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_off && !deact_go && !fault_hit && !stop_req) |=> $stable(lvl_q));

endmodule

// File: rtl/card_seq_fsm.sv
module card_seq_fsm
  import card_seq_pkg::*;
#(
  parameter int unsigned ACT_STEP  = 4,
  parameter int unsigned RST_DLY   = 8,
  parameter int unsigned DEACT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] start_lvl,
  input  logic       stop_req,
  input  logic       fault_hit,
  input  logic       rdy_mode,
  input  logic       supply_good,
  input  logic       card_event,
  input  logic       tmr_expired,
  output logic       slot_off,
  output logic       deact_go,
  output logic       stable,
  output logic [1:0] vsel,
  output logic       supply_en,
  output logic       card_rst,
  output logic       card_clk_en,
  output logic       card_io_en
);

  localparam int unsigned MAXLEN = max3(ACT_STEP, RST_DLY, DEACT_CYC);
  localparam int unsigned CNT_W  = $clog2(MAXLEN + 1);

  seq_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       lvl_q;
  logic             en_q, io_q, ck_q, rs_q;

  logic             live;
  logic             past_wait;
  logic             good_lost;
  logic             wait_abort;
  logic             timed;
  logic             phase_done;
  int unsigned      cur_len;

  assign live       = (state_q == S_WAIT) || (state_q == S_IO) ||
                      (state_q == S_CLK)  || (state_q == S_ON);
  assign past_wait  = (state_q == S_IO) || (state_q == S_CLK) || (state_q == S_ON);
  assign good_lost  = past_wait && !supply_good;
  assign wait_abort = (state_q == S_WAIT) && !rdy_mode && tmr_expired;
  assign deact_go   = live && (card_event || good_lost || stop_req || fault_hit || wait_abort);
  assign timed      = (state_q == S_IO) || (state_q == S_CLK) ||
                      (state_q == S_DRST) || (state_q == S_DCLK) || (state_q == S_DIO);

  always_comb begin
    case (state_q)
      S_IO:    cur_len = ACT_STEP;
      S_CLK:   cur_len = RST_DLY;
      default: cur_len = DEACT_CYC;
    endcase
  end

  assign phase_done = timed && phase_end(32'(cnt_q), cur_len);

  assign slot_off    = (state_q == S_OFF);
  assign stable      = (state_q == S_ON) && supply_good;
  assign vsel        = lvl_q;
  assign supply_en   = en_q;
  assign card_rst    = rs_q;
  assign card_clk_en = ck_q;
  assign card_io_en  = io_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      cnt_q   <= '0;
      lvl_q   <= 2'b00;
      en_q    <= 1'b0;
      io_q    <= 1'b0;
      ck_q    <= 1'b0;
      rs_q    <= 1'b0;
    end else if (deact_go) begin
      state_q <= S_DRST;
      cnt_q   <= '0;
      rs_q    <= 1'b0;
    end else begin
      if (timed) cnt_q <= cnt_q + 1'b1;
      case (state_q)
        S_OFF: if (start) begin
          state_q <= S_WAIT;
          en_q    <= 1'b1;
          lvl_q   <= start_lvl;
        end
        S_WAIT: if (rdy_mode && supply_good) begin
          state_q <= S_IO;
          io_q    <= 1'b1;
          cnt_q   <= '0;
        end
        S_IO: if (phase_done) begin
          state_q <= S_CLK;
          ck_q    <= 1'b1;
          cnt_q   <= '0;
        end
        S_CLK: if (phase_done) begin
          state_q <= S_ON;
          rs_q    <= 1'b1;
          cnt_q   <= '0;
        end
        S_DRST: if (phase_done) begin
          state_q <= S_DCLK;
          ck_q    <= 1'b0;
          cnt_q   <= '0;
        end
        S_DCLK: if (phase_done) begin
          state_q <= S_DIO;
          io_q    <= 1'b0;
          cnt_q   <= '0;
        end
        S_DIO: if (phase_done) begin
          state_q <= S_OFF;
          en_q    <= 1'b0;
          lvl_q   <= 2'b00;
          cnt_q   <= '0;
        end
        default: ;
      endcase
    end
  end

  a_r3_rst_needs_lines: assert property (@(posedge clk) disable iff (!rst_n)
    rs_q |-> (ck_q && io_q && en_q));

  a_r6_rst_before_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ck_q) |-> !rs_q);

  a_r6_io_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_q) |-> (!ck_q && !rs_q));

  a_r6_supply_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> (!io_q && !ck_q && !rs_q));

  a_r2_vsel_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != 2'b00) == en_q);

  a_r9_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && $past(en_q)) |-> $stable(lvl_q));

endmodule

// File: rtl/card_supply_seq.sv
module card_supply_seq
  import card_seq_pkg::*;
#(
  parameter int unsigned ACT_STEP  = 4,
  parameter int unsigned RST_DLY   = 8,
  parameter int unsigned DEACT_CYC = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       supply_good,
  input  logic       card_event,
  input  logic       supply_fault,
  input  logic       tmr_expired,
  output logic [1:0] vsel,
  output logic       supply_en,
  output logic       card_rst,
  output logic       card_clk_en,
  output logic       card_io_en
);

  logic       start, stop_req, fault_hit, rdy_mode, locked;
  logic       slot_off, deact_go, stable;
  logic [1:0] start_lvl;

  card_seq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .supply_fault(supply_fault), .slot_off(slot_off), .deact_go(deact_go),
    .stable(stable), .rd_data(rd_data), .start(start), .start_lvl(start_lvl),
    .stop_req(stop_req), .fault_hit(fault_hit), .rdy_mode(rdy_mode),
    .locked(locked)
  );

  card_seq_fsm #(
    .ACT_STEP(ACT_STEP), .RST_DLY(RST_DLY), .DEACT_CYC(DEACT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_lvl(start_lvl),
    .stop_req(stop_req), .fault_hit(fault_hit), .rdy_mode(rdy_mode),
    .supply_good(supply_good), .card_event(card_event), .tmr_expired(tmr_expired),
    .slot_off(slot_off), .deact_go(deact_go), .stable(stable), .vsel(vsel),
    .supply_en(supply_en), .card_rst(card_rst), .card_clk_en(card_clk_en),
    .card_io_en(card_io_en)
  );

  a_r8_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && slot_off) |=> !supply_en);

  a_r10_stable_active: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[STABLE_BIT] |-> (card_rst && supply_good));

endmodule

// File: tb/tb_card_supply_seq.sv
`timescale 1ns/1ps
module tb_card_supply_seq;

  localparam int ACT = 4;
  localparam int RSD = 8;
  localparam int DC  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       supply_good = 1'b0, card_event = 1'b0, supply_fault = 1'b0, tmr_expired = 1'b0;
  logic [1:0] vsel;
  logic       supply_en, card_rst, card_clk_en, card_io_en;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  card_supply_seq #(.ACT_STEP(ACT), .RST_DLY(RSD), .DEACT_CYC(DC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .supply_good(supply_good), .card_event(card_event), .supply_fault(supply_fault),
    .tmr_expired(tmr_expired), .vsel(vsel), .supply_en(supply_en), .card_rst(card_rst),
    .card_clk_en(card_clk_en), .card_io_en(card_io_en)
  );

  function automatic logic [7:0] exp_reg(input logic [1:0] lvl, input logic rdy,
                                         input logic arm, input logic stb, input logic lck);
    return {lvl, rdy, arm, stb, lck, 2'b00};
  endfunction

  function automatic logic [7:0] ctl(input logic [1:0] lvl, input logic rdy, input logic arm);
    return {lvl, rdy, arm, 4'b0000};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1;
    wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  // Full activation in ready mode with timing checks (R2, R3, R10).
  task automatic activate(input logic [1:0] lvl, input logic arm);
    wr(ctl(lvl, 1'b1, arm));
    chk(supply_en == 1'b1 && vsel == lvl, "R2 supply on with level", int'(vsel), int'(lvl));
    chk(rd_data[3] == 1'b0, "R10 not stable while waiting", int'(rd_data[3]), 0);
    supply_good = 1'b1;
    cyc();
    chk(card_io_en == 1'b1 && card_clk_en == 1'b0, "R3 io first", int'(card_io_en), 1);
    repeat (ACT - 1) cyc();
    chk(card_clk_en == 1'b0, "R3 clk not early", int'(card_clk_en), 0);
    cyc();
    chk(card_clk_en == 1'b1, "R3 clk on time", int'(card_clk_en), 1);
    repeat (RSD - 1) cyc();
    chk(card_rst == 1'b0, "R3 rst not early", int'(card_rst), 0);
    cyc();
    chk(card_rst == 1'b1, "R3 rst released", int'(card_rst), 1);
    chk(rd_data == exp_reg(lvl, 1'b1, arm, 1'b1, 1'b0), "R10 status when active",
        int'(rd_data), int'(exp_reg(lvl, 1'b1, arm, 1'b1, 1'b0)));
  endtask

  // Trigger already applied at this negedge; checks the teardown order (R6).
  task automatic teardown(input string tag, input bit clk_was_on);
    cyc();
    card_event = 1'b0; supply_fault = 1'b0; tmr_expired = 1'b0; wr_en = 1'b0;
    chk(card_rst == 1'b0, {tag, " R6 rst drops first"}, int'(card_rst), 0);
    chk(rd_data[7:6] == 2'b00, {tag, " level field cleared"}, int'(rd_data[7:6]), 0);
    if (clk_was_on) begin
      repeat (DC - 1) cyc();
      chk(card_clk_en == 1'b1, {tag, " R6 clk held one phase"}, int'(card_clk_en), 1);
      cyc();
      chk(card_clk_en == 1'b0 && card_io_en == 1'b1, {tag, " R6 clk stops before io"},
          int'(card_io_en), 1);
      repeat (DC) cyc();
      chk(card_io_en == 1'b0 && supply_en == 1'b1, {tag, " R6 io off, supply on"},
          int'(supply_en), 1);
      repeat (DC - 1) cyc();
    end else begin
      repeat (3 * DC - 1) cyc();
    end
    chk(supply_en == 1'b1, {tag, " R6 supply held to last phase"}, int'(supply_en), 1);
    cyc();
    chk(supply_en == 1'b0 && vsel == 2'b00, {tag, " R6 supply off last"}, int'(supply_en), 0);
  endtask

  initial begin
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    chk(rd_data == 8'h00, "R1 reset register", int'(rd_data), 0);
    chk({supply_en, vsel, card_rst, card_clk_en, card_io_en} == 6'b0, "R1 reset outputs",
        int'({supply_en, vsel, card_rst, card_clk_en, card_io_en}), 0);
    rst_n = 1'b1;
    cyc();

    // Randomized activations and deactivation causes (R2, R3, R5, R6, R9)
    for (int i = 0; i < 12; i++) begin
      logic [1:0] lvl;
      int cause;
      lvl = 2'($urandom_range(1, 3));
      cause = $urandom_range(0, 2);
      activate(lvl, 1'b0);
      repeat ($urandom_range(0, 5)) cyc();
      if (cause == 0) begin
        card_event = 1'b1;
        teardown("R5 card event", 1'b1);
      end else if (cause == 1) begin
        supply_good = 1'b0;
        teardown("R5 supply drop", 1'b1);
      end else begin
        wr_en = 1'b1; wr_data = ctl(2'b00, 1'b1, 1'b0);
        teardown("R9 write zero", 1'b1);
      end
    end

    // R9: a new level while active is ignored
    activate(2'b01, 1'b0);
    wr(ctl(2'b11, 1'b1, 1'b0));
    chk(rd_data[7:6] == 2'b01 && vsel == 2'b01, "R9 level unchanged", int'(vsel), 1);
    chk(card_rst == 1'b1 && card_clk_en == 1'b1, "R9 lines unchanged", int'(card_rst), 1);
    card_event = 1'b1;
    teardown("R5 after ignored write", 1'b1);

    // R4: hold mode; good alone does not advance, timer aborts
    supply_good = 1'b0;
    wr(ctl(2'b10, 1'b0, 1'b0));
    chk(supply_en == 1'b1 && vsel == 2'b10, "R4 supply on", int'(vsel), 2);
    supply_good = 1'b1;
    repeat (4) cyc();
    chk(card_io_en == 1'b0, "R4 no progress without ready mode", int'(card_io_en), 0);
    tmr_expired = 1'b1;
    teardown("R4 timer abort", 1'b0);

    // R7, R8: armed fault and lockout
    activate(2'b11, 1'b1);
    supply_fault = 1'b1;
    cyc();
    supply_fault = 1'b0;
    chk(rd_data == exp_reg(2'b00, 1'b1, 1'b0, 1'b0, 1'b1), "R7 fault status",
        int'(rd_data), int'(exp_reg(2'b00, 1'b1, 1'b0, 1'b0, 1'b1)));
    chk(card_rst == 1'b0, "R7 rst drops on fault", int'(card_rst), 0);
    repeat (3 * DC) cyc();
    chk(supply_en == 1'b0, "R7 fault teardown done", int'(supply_en), 0);
    wr(ctl(2'b10, 1'b1, 1'b0));
    chk(supply_en == 1'b0 && rd_data[7:6] == 2'b00, "R8 locked write ignored",
        int'(supply_en), 0);
    chk(rd_data[2] == 1'b1, "R8 lock still set", int'(rd_data[2]), 1);
    wr(ctl(2'b00, 1'b1, 1'b0));
    chk(rd_data[2] == 1'b0 && supply_en == 1'b0, "R8 lock cleared", int'(rd_data[2]), 0);
    activate(2'b10, 1'b0);
    supply_good = 1'b0;
    teardown("R8 reactivated run", 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule